// File: doc/BRIEF.md
# Counting ADC Sequencer

This block is the digital half of a counting analog-to-digital converter. It presents an N-bit code to an external binary-weighted DAC, so full scale is 2^N − 1 least significant steps, and reads one external comparator bit that is high while the DAC output sits below the analog input. The comparator bit is asynchronous to the block clock, so it passes through a chain of synchronising flops before any decision uses it.

There are two modes. In ramp mode a start pulse clears the code to zero, and the code then climbs one step per clock. A conversion ends at the first code the comparator reports as not below the input. That code is copied into a result register and announced by a one-clock valid pulse, and the block then waits for the next start. Each code is tagged on its way through a delay line that matches the synchroniser, so the code that gets latched is the one the comparator actually judged, not the code on the bus when the verdict arrives. If full scale is judged and the input is still above it, full scale is latched and an overrange flag is raised. In tracking mode the code steps up or down on every clock toward the input, never restarts, and is mirrored into the result with valid held high.

Top module: `cnt_adc_seq`

## Requirements
- R1: A low synchronous reset (`rst_n` sampled at a clock edge) clears `dac_code`, `result`, `valid` and `overrange` to zero, and ramp mode comes out of reset idle, holding its code.
- R2: In ramp mode, a `start` sampled high while idle sets the code to 0 on that edge. The code then rises by exactly one per clock until the conversion ends, never passes 2^N − 1, and holds its value while idle.
- R3: `cmp_below` = 1 means the DAC output is below the input. It is synchronised through SYNC_STAGES flops. A ramp conversion ends at the first code judged with `cmp_below` = 0: `result` takes that code and `valid` is high for exactly one clock. For an input needing code v, `valid` rises on the edge v + SYNC_STAGES + 1 edges after the edge that accepted `start`.
- R4: If code 2^N − 1 is judged with `cmp_below` still 1, `result` becomes all ones, `overrange` is set and `valid` pulses 2^N + SYNC_STAGES edges after the start edge. `overrange` stays set until the next accepted start, a mode change or reset. A conversion that ends in range leaves it 0.
- R5: A `start` pulse arriving while a ramp conversion is running has no effect on its result or timing.
- R6: In tracking mode (`track_en` = 1) the code moves by one on every clock: up when the synchronised comparator is 1 and down when it is 0. It saturates at 0 and at 2^N − 1 without wrapping.
- R7: In tracking mode, from the second clock after entering it, `valid` is held high and `result` equals `dac_code` on every clock.
- R8: A change of `track_en` clears `dac_code`, `result`, `valid` and `overrange` on the next edge and leaves ramp mode idle.
- R9: With a comparator that responds within the same cycle and the default two synchroniser stages, a tracked input settles into a limit cycle that keeps the code within 4 steps of the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| track_en | input | 1 | 0 selects ramp conversions, 1 selects continuous tracking |
| start | input | 1 | Begins a ramp conversion when sampled high while idle |
| cmp_below | input | 1 | Asynchronous comparator bit, 1 while DAC output is below the input |
| dac_code | output | WIDTH | Code driven to the external DAC |
| result | output | WIDTH | Latched conversion result |
| valid | output | 1 | One-clock pulse per ramp result; held high while tracking |
| overrange | output | 1 | Set when a ramp conversion reaches full scale without a trip |

## Verification
A misaligned code delay line or a stale comparator tag shows at the ports as a result off by one or two steps, or a result near zero, from the very first ramp conversion. It is visible on the valid edge, which is itself checked against its exact cycle. A wrong step rule or a missing saturation shows as a code jump larger than one step within a clock of the fault. It also shows as a tracked code that drifts out of its four-step window or wraps at zero or full scale within a few hundred cycles. Stale state after a mode change appears on the very next edge as a nonzero code, result or flag.

// File: rtl/cadc_pkg.sv
package cadc_pkg;

    // Phase of the ramp conversion controller
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } cadc_phase_e;

endpackage

// File: rtl/cadc_sync.sv
// Chain of flops that brings the asynchronous comparator bit into the clock domain.
module cadc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES:0] chain;

    assign chain[0] = async_in;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain[i+1] <= 1'b0;
            end else begin
                chain[i+1] <= chain[i];
            end
        end
    end

    assign sync_out = chain[STAGES];

endmodule

// File: rtl/cadc_codepipe.sv
// Tagged delay line: keeps each code aligned with the comparator verdict about it.
module cadc_codepipe #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             in_tag,
    input  logic [WIDTH-1:0] in_code,
    output logic             out_tag,
    output logic [WIDTH-1:0] out_code
);

    logic [DEPTH:0]            tag_q;
    logic [DEPTH:0][WIDTH-1:0] code_q;

    assign tag_q[0]  = in_tag;
    assign code_q[0] = in_code;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                tag_q[i+1]  <= 1'b0;
                code_q[i+1] <= '0;
            end else begin
                tag_q[i+1]  <= tag_q[i];
                code_q[i+1] <= code_q[i];
            end
        end
    end

    assign out_tag  = tag_q[DEPTH];
    assign out_code = code_q[DEPTH];

endmodule

// File: rtl/cadc_step.sv
// Next-code function: clear, hold, or a saturating single step up or down.
module cadc_step #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             clr,
    input  logic             hold,
    input  logic             up,
    output logic [WIDTH-1:0] nxt
);

    localparam logic [WIDTH-1:0] TOP = '1;
    localparam logic [WIDTH-1:0] BOT = '0;

    always_comb begin
        if (clr) begin
            nxt = BOT;
        end else if (hold) begin
            nxt = cur;
        end else if (up) begin
            nxt = (cur == TOP) ? cur : cur + 1'b1;
        end else begin
            nxt = (cur == BOT) ? cur : cur - 1'b1;
        end
    end

endmodule

// File: rtl/cnt_adc_seq.sv
module cnt_adc_seq
    import cadc_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             track_en,
    input  logic             start,
    input  logic             cmp_below,
    output logic [WIDTH-1:0] dac_code,
    output logic [WIDTH-1:0] result,
    output logic             valid,
    output logic             overrange
);

    localparam logic [WIDTH-1:0] CODE_MAX  = '1;
    localparam logic [WIDTH-1:0] CODE_ZERO = '0;

    typedef struct packed {
        cadc_phase_e      phase;
        logic             trk;
        logic [WIDTH-1:0] code;
        logic [WIDTH-1:0] res;
        logic             vld;
        logic             ovr;
    } seq_t;

    seq_t st_d, st_q;

    logic             cmp_s;
    logic             p_tag;
    logic [WIDTH-1:0] p_code;
    logic             mode_chg;
    logic             accept;
    logic             running;
    logic             judging;
    logic             trip;
    logic             full;
    logic             live_trk;
    logic             step_clr;
    logic             step_hold;
    logic             step_up;
    logic [WIDTH-1:0] step_nxt;

    cadc_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (cmp_below),
        .sync_out (cmp_s)
    );

    cadc_codepipe #(
        .WIDTH (WIDTH),
        .DEPTH (SYNC_STAGES)
    ) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (step_clr),
        .in_tag   (running),
        .in_code  (st_q.code),
        .out_tag  (p_tag),
        .out_code (p_code)
    );

    cadc_step #(
        .WIDTH (WIDTH)
    ) u_step (
        .cur  (st_q.code),
        .clr  (step_clr),
        .hold (step_hold),
        .up   (step_up),
        .nxt  (step_nxt)
    );

    // Decisions for this cycle
    always_comb begin
        mode_chg  = (track_en != st_q.trk);
        live_trk  = !mode_chg && st_q.trk;
        running   = !mode_chg && !st_q.trk && (st_q.phase == PH_RUN);
        accept    = !mode_chg && !st_q.trk && (st_q.phase == PH_IDLE) && start;
        judging   = running && p_tag;
        trip      = judging && !cmp_s;
        full      = judging && cmp_s && (p_code == CODE_MAX);
        step_clr  = mode_chg || accept;
        step_hold = !(live_trk || (running && !trip && !full));
        step_up   = live_trk ? cmp_s : 1'b1;
    end

    // Next state
    always_comb begin
        st_d      = st_q;
        st_d.code = step_nxt;
        st_d.trk  = track_en;
        if (mode_chg) begin
            st_d.phase = PH_IDLE;
            st_d.res   = CODE_ZERO;
            st_d.vld   = 1'b0;
            st_d.ovr   = 1'b0;
        end else if (st_q.trk) begin
            st_d.phase = PH_IDLE;
            st_d.res   = step_nxt;
            st_d.vld   = 1'b1;
            st_d.ovr   = 1'b0;
        end else begin
            st_d.vld = 1'b0;
            if (accept) begin
                st_d.phase = PH_RUN;
                st_d.ovr   = 1'b0;
            end
            if (trip) begin
                st_d.phase = PH_IDLE;
                st_d.res   = p_code;
                st_d.vld   = 1'b1;
            end else if (full) begin
                st_d.phase = PH_IDLE;
                st_d.res   = CODE_MAX;
                st_d.vld   = 1'b1;
                st_d.ovr   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.trk <= track_en;
        end else begin
            st_q <= st_d;
        end
    end

    assign dac_code  = st_q.code;
    assign result    = st_q.res;
    assign valid     = st_q.vld;
    assign overrange = st_q.ovr;

endmodule

// File: rtl/cadc_chk.sv
module cadc_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             track_en,
    input logic             valid,
    input logic             overrange,
    input logic [WIDTH-1:0] dac_code,
    input logic [WIDTH-1:0] result
);

    localparam logic [WIDTH-1:0] TOP = '1;
    localparam logic [WIDTH-1:0] BOT = '0;

    // R3
    ramp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !track_en) |=> !valid);

    // R4
    ovr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrange |-> (result == TOP));

    // R7
    trk_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(track_en) && $past(track_en, 2)) |-> (valid && result == dac_code));

    // R6
    trk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(track_en) && $past(track_en, 2)) |->
        (dac_code == $past(dac_code) || dac_code == $past(dac_code) + 1'b1 ||
         dac_code == $past(dac_code) - 1'b1));

    // R6
    trk_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(track_en) && $past(track_en, 2)) |->
        !(($past(dac_code) == TOP && dac_code == BOT) || ($past(dac_code) == BOT && dac_code == TOP)));

endmodule

bind cnt_adc_seq cadc_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .track_en  (track_en),
    .valid     (valid),
    .overrange (overrange),
    .dac_code  (dac_code),
    .result    (result)
);

// File: tb/sim_cnt_adc_seq.sv
module sim_cnt_adc_seq;

    localparam int CLK_PERIOD = 10;
    localparam int W    = 8;
    localparam int MAXC = (1 << W) - 1;
    localparam int LAG  = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         track_en = 1'b0;
    logic         start = 1'b0;
    logic         cmp_below;
    logic [W-1:0] dac_code;
    logic [W-1:0] result;
    logic         valid;
    logic         overrange;
    int           vin = 0;
    int           n_chk = 0;
    int           n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Comparator model that answers within the same cycle
    assign cmp_below = (int'(dac_code) < vin);

    cnt_adc_seq #(.WIDTH(W), .SYNC_STAGES(LAG)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .track_en  (track_en),
        .start     (start),
        .cmp_below (cmp_below),
        .dac_code  (dac_code),
        .result    (result),
        .valid     (valid),
        .overrange (overrange)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // One ramp conversion; optional extra start at step restart_at
    task automatic run_ramp(input int v, input int restart_at);
        int lat = -1;
        int held;
        bit climb_ok = 1'b1;
        int exp_lat = (v > MAXC) ? (MAXC + 1 + LAG) : (v + LAG + 1);
        int exp_res = (v > MAXC) ? MAXC : v;
        vin = v;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(dac_code == 0 || exp_lat == 1, "R2 code cleared by start", dac_code, 0);
        for (int k = 1; k < 600; k++) begin
            @(negedge clk);
            if (valid) begin
                lat = k;
                break;
            end
            if (int'(dac_code) != ((k > MAXC) ? MAXC : k)) climb_ok = 1'b0;
            start = (k == restart_at);
        end
        start = 1'b0;
        chk(climb_ok, "R2 one step per clock", 0, 1);
        chk(lat == exp_lat, (restart_at > 0) ? "R5 latency with extra start" : "R3 valid latency", lat, exp_lat);
        chk(int'(result) == exp_res, (restart_at > 0) ? "R5 result with extra start" : "R3 result code", result, exp_res);
        chk(overrange == (v > MAXC), "R4 overrange flag", overrange, v > MAXC);
        held = dac_code;
        @(negedge clk);
        chk(!valid, "R3 valid one clock", valid, 0);
        repeat (3) @(negedge clk);
        chk(int'(dac_code) == held, "R2 code holds when idle", dac_code, held);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        chk(dac_code == 0 && result == 0, "R1 reset code/result", {dac_code, result}, 0);
        chk(!valid && !overrange, "R1 reset flags", {valid, overrange}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(dac_code == 0 && !valid, "R1 idle after reset", dac_code, 0);
    endtask

    task automatic t_ramp_values();
        run_ramp(0, 0);
        run_ramp(1, 0);
        run_ramp(37, 0);
        run_ramp(200, 0);
        run_ramp(MAXC, 0);
    endtask

    task automatic t_overrange();
        run_ramp(MAXC + 1, 0);
        repeat (10) @(negedge clk);
        chk(overrange, "R4 overrange persists", overrange, 1);
        run_ramp(10, 0);
        chk(!overrange, "R4 cleared by new start", overrange, 0);
        run_ramp(MAXC + 1, 0);
    endtask

    task automatic t_restart_ignored();
        run_ramp(50, 10);
    endtask

    task automatic t_to_track();
        chk(overrange, "R8 overrange set before change", overrange, 1);
        vin = 100;
        @(negedge clk) track_en = 1'b1;
        @(negedge clk);
        chk(dac_code == 0 && result == 0, "R8 code/result cleared", {dac_code, result}, 0);
        chk(!valid && !overrange, "R8 flags cleared", {valid, overrange}, 0);
        @(negedge clk);
        chk(valid, "R7 valid high in tracking", valid, 1);
    endtask

    task automatic t_track_follow(input int v);
        bit step_ok = 1'b1;
        bit near_ok = 1'b1;
        bit mirror_ok = 1'b1;
        int prev;
        vin = v;
        repeat (300) @(negedge clk);
        prev = dac_code;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (int'(dac_code) - prev > 1 || prev - int'(dac_code) > 1) step_ok = 1'b0;
            if (int'(dac_code) - v > 4 || v - int'(dac_code) > 4) near_ok = 1'b0;
            if (!valid || result != dac_code) mirror_ok = 1'b0;
            prev = dac_code;
        end
        chk(step_ok, "R6 single steps", 0, 1);
        chk(near_ok, "R9 code within 4 of input", dac_code, v);
        chk(mirror_ok, "R7 result mirrors code", result, dac_code);
    endtask

    task automatic t_track_sat();
        bit lo_ok = 1'b1;
        bit hi_ok = 1'b1;
        vin = 0;
        repeat (300) @(negedge clk);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (dac_code != 0) lo_ok = 1'b0;
        end
        chk(lo_ok, "R6 saturates at zero", dac_code, 0);
        vin = MAXC + 1;
        repeat (300) @(negedge clk);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (int'(dac_code) != MAXC) hi_ok = 1'b0;
        end
        chk(hi_ok, "R6 saturates at full scale", dac_code, MAXC);
    endtask

    task automatic t_to_ramp();
        @(negedge clk) track_en = 1'b0;
        @(negedge clk);
        chk(dac_code == 0 && result == 0 && !valid, "R8 leave tracking clears", {dac_code, result, valid}, 0);
        repeat (5) @(negedge clk);
        chk(dac_code == 0 && !valid, "R8 ramp idle after change", dac_code, 0);
        run_ramp(20, 0);
    endtask

    task automatic t_reset_mid_run();
        vin = 200;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(dac_code == 0 && result == 0 && !valid && !overrange, "R1 reset mid conversion", dac_code, 0);
        rst_n = 1'b1;
        repeat (250) @(negedge clk);
        chk(dac_code == 0 && !valid, "R1 no conversion resumes", dac_code, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        finish_run();
    end

    initial begin
        t_reset();
        t_ramp_values();
        t_restart_ignored();
        t_overrange();
        t_to_track();
        t_track_follow(100);
        t_track_follow(7);
        t_track_sat();
        t_to_ramp();
        t_reset_mid_run();
        finish_run();
    end

endmodule